// File: doc/BRIEF.md
# Bit-Serial Arithmetic Node for Evolved Regression Trees

This block is one node of a program tree built for symbolic regression. Each of its two operands arrives as a 16-bit two's complement word on a single wire, least significant bit first, and a strobe marks bit 0 of every word. A 3-bit operation code picks what the node does. It can add the operands, subtract the second from the first, or multiply them and keep the upper half of the signed product. As a leaf it sends out a 16-bit constant held inside the node, or the serial input variable, in place of any arithmetic.

Each operation takes exactly 33 clock cycles from the input strobe to the output strobe. Nodes can therefore be chained level by level into a pipeline whose depth is fixed and independent of the functions chosen. Once the pipeline is full, the node accepts a new operand pair every 16 cycles.

Top module: `serial_arith_node`

## Requirements
- R1: After a synchronous active-low reset, `res_bit_o` and `res_frame_o` are 0.
- R2: All words are 16 bits, least significant bit first. `frame_i` is high only with bit 0. `res_frame_o` pulses for one cycle, carrying result bit 0, exactly 33 rising edges after the edge that sampled `frame_i` high. Result bits 1 to 15 follow on consecutive cycles.
- R3: Op code 0 outputs the sum of the two operands, wrapped modulo 2^16.
- R4: Op code 1 outputs operand A minus operand B, wrapped modulo 2^16.
- R5: Op code 2 outputs bits 31..16 of the signed 32-bit product of A and B.
- R6: Op code 3 outputs `cfg_const_i`. The operand bits have no effect on the result.
- R7: Op code 4 outputs the word received on `var_bit_i`. The operand bits have no effect on the result.
- R8: Op codes 5, 6 and 7 output an all-zero word.
- R9: The op code and the constant are sampled only in the cycle that carries bit 15 of the operands. Values they hold earlier in the word have no effect.
- R10: Words whose strobes are exactly 16 cycles apart are each processed correctly, back to back, with no gap in the output stream.
- R11: Once the bits of a result have all been sent and no further result is due, `res_bit_o` and `res_frame_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Strobe marking bit 0 of the incoming words |
| a_bit_i | input | 1 | Serial operand A, LSB first |
| b_bit_i | input | 1 | Serial operand B, LSB first |
| var_bit_i | input | 1 | Serial input variable, LSB first |
| cfg_op_i | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 const, 4 var) |
| cfg_const_i | input | 16 | Embedded constant for the const code |
| res_bit_o | output | 1 | Serial result, LSB first |
| res_frame_o | output | 1 | Strobe marking bit 0 of the result |

## Verification
The sharpest collision happens when strobes arrive exactly 16 cycles apart. In one cycle, the multiplier takes its final step and hands the result to the output register, and on the same edge the next operand pair is loaded into it. At that same edge the captured op code and constant are also replaced. Long back-to-back runs with a random op code per word provoke this collision. Extra words change the op code midway through the word to test the bit-15 sampling rule. A queue-based reference model predicts both output pins for every cycle. Any result that leaks from one word into the next shows up as a per-cycle mismatch.

// File: rtl/serial_node_pkg.sv
// Shared width and operation codes for the bit-serial tree node.
// Assumes every tree node in the pipeline uses the same word width.
package serial_node_pkg;
    localparam int NODE_W = 16;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_CONST = 3'd3,
        OP_VAR   = 3'd4
    } node_op_e;
endpackage

// File: rtl/node_deser.sv
// Serial-to-parallel capture for LANES serial lanes sharing one frame strobe.
// Also latches a parallel sideband word in the cycle that carries the last bit.
// Assumes a frame strobe never arrives while a word is still being received.
module node_deser #(
    parameter int W      = 16,
    parameter int LANES  = 3,
    parameter int SIDE_W = 19
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_i,
    input  logic [LANES-1:0]          bits_i,
    input  logic [SIDE_W-1:0]         side_i,
    output logic [LANES-1:0][W-1:0]   words_o,
    output logic [SIDE_W-1:0]         side_o,
    output logic                      cap_o
);
    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(W - 1);

    logic [IDX_W-1:0] idx_q;
    logic             run_q;
    logic             active;
    logic [IDX_W-1:0] cur_idx;
    logic             last_bit;

    // Current bit position: a strobe restarts at bit 0
    always_comb begin
        active   = frame_i | run_q;
        cur_idx  = frame_i ? '0 : idx_q;
        last_bit = active && (cur_idx == LAST_IDX);
    end

    // Bit counter and running flag for the word in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            run_q <= 1'b0;
        end else begin
            idx_q <= active ? cur_idx + 1'b1 : '0;
            run_q <= active && !last_bit;
        end
    end

    // Capture pulse, one cycle after the last bit has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o  <= 1'b0;
            side_o <= '0;
        end else begin
            cap_o <= last_bit;
            if (last_bit) side_o <= side_i;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] sr_q;
        // Shift each lane in LSB first and publish the full word on the last bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr_q       <= '0;
                words_o[g] <= '0;
            end else if (active) begin
                sr_q <= {bits_i[g], sr_q[W-1:1]};
                if (last_bit) words_o[g] <= {bits_i[g], sr_q[W-1:1]};
            end
        end
    end

    AST_CAP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> !cap_o);  // R2
endmodule

// File: rtl/node_serial_mul.sv
// Shift-and-add signed multiplier, one multiplier bit per clock (W steps).
// The top bit of the multiplier has negative weight, so the product is two's complement.
// A new start may coincide with the final step; the final sum is then taken from prod_hi_o.
module node_serial_mul #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic          done_o,
    output logic [W-1:0]  prod_hi_o
);
    localparam int PW     = 2 * W;
    localparam int STEP_W = $clog2(W);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(W - 1);

    logic [PW-1:0]     mcand_q;
    logic [W-1:0]      mplier_q;
    logic [PW-1:0]     acc_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              last_step;
    logic [PW-1:0]     addend;
    logic [PW-1:0]     acc_next;

    // Partial product for this step; the sign bit step subtracts
    always_comb begin
        last_step = (step_q == LAST_STEP);
        addend    = mplier_q[0] ? mcand_q : '0;
        acc_next  = last_step ? acc_q - addend : acc_q + addend;
        done_o    = busy_q && last_step;
        prod_hi_o = acc_next[PW-1:W];
    end

    // Load operands on start, otherwise advance one multiplier bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            step_q   <= '0;
            busy_q   <= 1'b0;
        end else if (start_i) begin
            mcand_q  <= {{W{a_i[W-1]}}, a_i};
            mplier_q <= b_i;
            acc_q    <= '0;
            step_q   <= '0;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            acc_q    <= acc_next;
            step_q   <= step_q + 1'b1;
            if (last_step) busy_q <= 1'b0;
        end
    end

    AST_MUL_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (!busy_q || last_step));  // R10
    AST_MUL_DONE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R5
endmodule

// File: rtl/node_serializer.sv
// Parallel-to-serial result shifter, LSB first, with a bit-0 strobe.
// Shifts in zeros, so the line is quiet once a word has left.
module node_serializer #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [W-1:0]  word_i,
    output logic          bit_o,
    output logic          frame_o
);
    logic [W-1:0] sr_q;

    // Load a result word or shift the previous one out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            frame_o <= 1'b0;
        end else begin
            sr_q    <= load_i ? word_i : (sr_q >> 1);
            frame_o <= load_i;
        end
    end

    assign bit_o = sr_q[0];

    AST_OUT_FRAME_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);  // R2
endmodule

// File: rtl/serial_arith_node.sv
// One function or terminal node of a bit-serial regression tree.
// Captures A, B and the variable word, then runs the serial multiplier for every op
// so that all codes see the same 33-cycle latency; a one-stage result register
// pads the path to that length. Assumes frame strobes are at least W cycles apart.
module serial_arith_node
    import serial_node_pkg::*;
#(
    parameter int W = NODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_i,
    input  logic            a_bit_i,
    input  logic            b_bit_i,
    input  logic            var_bit_i,
    input  logic [OP_W-1:0] cfg_op_i,
    input  logic [W-1:0]    cfg_const_i,
    output logic            res_bit_o,
    output logic            res_frame_o
);
    localparam int LANES  = 3;
    localparam int SIDE_W = OP_W + W;

    logic [LANES-1:0][W-1:0] words;
    logic [SIDE_W-1:0]       side_cap;
    logic                    cap;
    logic                    mul_done;
    logic [W-1:0]            mul_hi;

    logic [W-1:0]    opa_q, opb_q, var_q, const_q;
    logic [OP_W-1:0] op_q;
    logic [W-1:0]    res_sel;
    logic [W-1:0]    res_q;
    logic            res_vld_q;

    node_deser #(.W(W), .LANES(LANES), .SIDE_W(SIDE_W)) deser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_i),
        .bits_i  ({var_bit_i, b_bit_i, a_bit_i}),
        .side_i  ({cfg_op_i, cfg_const_i}),
        .words_o (words),
        .side_o  (side_cap),
        .cap_o   (cap)
    );

    node_serial_mul #(.W(W)) mul_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cap),
        .a_i       (words[0]),
        .b_i       (words[1]),
        .done_o    (mul_done),
        .prod_hi_o (mul_hi)
    );

    // Hold this word's operands and configuration while the multiplier runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q   <= '0;
            opb_q   <= '0;
            var_q   <= '0;
            const_q <= '0;
            op_q    <= '0;
        end else if (cap) begin
            opa_q   <= words[0];
            opb_q   <= words[1];
            var_q   <= words[2];
            const_q <= side_cap[W-1:0];
            op_q    <= side_cap[SIDE_W-1:W];
        end
    end

    // Pick the node output by op code
    always_comb begin
        case (op_q)
            OP_ADD:   res_sel = opa_q + opb_q;
            OP_SUB:   res_sel = opa_q - opb_q;
            OP_MUL:   res_sel = mul_hi;
            OP_CONST: res_sel = const_q;
            OP_VAR:   res_sel = var_q;
            default:  res_sel = '0;
        endcase
    end

    // Latency padding stage between the multiplier finish and the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_vld_q <= 1'b0;
        end else begin
            res_vld_q <= mul_done;
            if (mul_done) res_q <= res_sel;
        end
    end

    node_serializer #(.W(W)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (res_vld_q),
        .word_i  (res_q),
        .bit_o   (res_bit_o),
        .frame_o (res_frame_o)
    );

    AST_RESULT_NOT_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !res_vld_q);  // R10
endmodule

// File: tb/serial_arith_node_tb.sv
// Queue-style reference model: each sent word schedules its expected output bits
// at absolute edge numbers; both outputs are compared on every clock.
module serial_arith_node_tb_top;
    localparam int W   = 16;
    localparam int LAT = 33;
    localparam int N   = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_i = 1'b0, a_bit = 1'b0, b_bit = 1'b0, v_bit = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] cval = 16'd0;
    logic res_bit, res_frame;

    serial_arith_node dut_i (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .a_bit_i(a_bit), .b_bit_i(b_bit), .var_bit_i(v_bit),
        .cfg_op_i(op), .cfg_const_i(cval),
        .res_bit_o(res_bit), .res_frame_o(res_frame)
    );

    always #10 clk = ~clk;

    int ec = 0;
    always @(posedge clk) ec <= ec + 1;

    bit exp_f [N];
    bit exp_b [N];
    int exp_r [N];
    int total = 0, bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    function automatic logic [15:0] model(input logic [2:0] m, input logic [15:0] a, b, v, c);
        int ia, ib, p;
        logic [31:0] pv;
        ia = int'($signed(a));
        ib = int'($signed(b));
        case (m)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: begin p = ia * ib; pv = p; return pv[31:16]; end
            3'd3: return c;
            3'd4: return v;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int req_of(input logic [2:0] m);
        case (m)
            3'd0: return 3;
            3'd1: return 4;
            3'd2: return 5;
            3'd3: return 6;
            3'd4: return 7;
            default: return 8;
        endcase
    endfunction

    // Compare both outputs against the schedule at the current edge count
    task automatic tick();
        @(negedge clk);
        if (chk_en && ec < N) begin
            total++;
            if (res_frame !== exp_f[ec]) begin
                bad++;
                $display("FAIL R2 edge %0d: frame=%b expected %b", ec, res_frame, exp_f[ec]);
            end else if (res_bit !== exp_b[ec]) begin
                bad++;
                $display("FAIL R%0d edge %0d: bit=%b expected %b", exp_r[ec], ec, res_bit, exp_b[ec]);
            end
        end
    endtask

    // Send one word; m_early/c_early are driven on bits 0..7, m/c on bits 8..15 (R9)
    task automatic send(input logic [2:0] m_early, input logic [2:0] m,
                        input logic [15:0] a, b, v, c_early, c);
        logic [15:0] r;
        int n, rq;
        r  = model(m, a, b, v, c);
        n  = ec + 1;
        rq = (m_early != m || c_early != c) ? 9 : req_of(m);
        for (int i = 0; i < W; i++) begin
            frame_i = (i == 0);
            a_bit = a[i]; b_bit = b[i]; v_bit = v[i];
            op   = (i < 8) ? m_early : m;
            cval = (i < 8) ? c_early : c;
            if (n + LAT + i < N) begin
                exp_b[n + LAT + i] = r[i];
                exp_f[n + LAT + i] = (i == 0);
                exp_r[n + LAT + i] = rq;
            end
            tick();
        end
        frame_i = 1'b0;
    endtask

    task automatic word(input logic [2:0] m, input logic [15:0] a, b);
        send(m, m, a, b, 16'h0000, 16'h0000, 16'h0000);
    endtask

    // Idle cycles with random noise on the data lines (R11)
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            frame_i = 1'b0;
            a_bit = 1'($urandom); b_bit = 1'($urandom); v_bit = 1'($urandom);
            tick();
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_r[i] = 11;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;   // R1 reset state
        if (res_bit !== 1'b0 || res_frame !== 1'b0) begin
            bad++;
            $display("FAIL R1: bit=%b frame=%b expected 0 0", res_bit, res_frame);
        end
        chk_en = 1'b1;

        // R3 add, including wrap
        word(3'd0, 16'd3, 16'd4);
        word(3'd0, 16'h7FFF, 16'd1);
        word(3'd0, 16'hFFFB, 16'hFFF9);
        idle(40);
        // R4 sub, including wrap
        word(3'd1, 16'd10, 16'd3);
        word(3'd1, 16'h8000, 16'd1);
        word(3'd1, 16'd3, 16'd10);
        idle(5);
        // R5 mul corners
        word(3'd2, 16'd300, 16'd400);
        word(3'd2, 16'h8000, 16'h8000);
        word(3'd2, 16'hFFFF, 16'hFFFF);
        word(3'd2, 16'h7FFF, 16'h7FFF);
        word(3'd2, 16'h8000, 16'd1);
        word(3'd2, 16'd1234, 16'(-5678));
        idle(20);
        // R6 constant with noise on operands
        send(3'd3, 3'd3, 16'hAAAA, 16'h5555, 16'h0F0F, 16'hBEEF, 16'hBEEF);
        // R7 input variable
        send(3'd4, 3'd4, 16'h1111, 16'h2222, 16'h1357, 16'h0000, 16'h0000);
        // R8 unused codes
        word(3'd5, 16'h1234, 16'h4321);
        word(3'd6, 16'hFFFF, 16'hFFFF);
        word(3'd7, 16'h00FF, 16'h0F00);
        idle(3);
        // R9 late sampling of op code and constant
        send(3'd0, 3'd2, 16'd1000, 16'd2000, 16'h0000, 16'h0000, 16'h0000);
        send(3'd2, 3'd3, 16'h7FFF, 16'h7FFF, 16'h0000, 16'h1111, 16'hC0DE);
        send(3'd3, 3'd1, 16'd50, 16'd80, 16'h0000, 16'h9999, 16'h0001);
        // R10 long back-to-back run with random codes
        for (int k = 0; k < 60; k++) begin
            logic [2:0] m;
            logic [15:0] c;
            m = 3'($urandom_range(0, 4));
            c = 16'($urandom);
            send(m, m, 16'($urandom), 16'($urandom), 16'($urandom), c, c);
        end
        // R11 drain and stay quiet
        idle(60);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end
endmodule